// File: doc/BRIEF.md
# General-Purpose Port Register Bank

This block is the register store for one 16-bit general-purpose port. It sits on a simple memory-mapped bus. The bus gives a select, a write enable, an address, an access size and write data. It returns read data and an error flag. The bank holds eight 16-bit registers:

- the pin data register;
- two interrupt-mask registers, A and B;
- a direction register;
- a polarity register;
- an edge-select register;
- a both-edges register;
- an input-enable register.

The data register and each mask register can be written directly. Each of them also has three alias addresses that clear, set or toggle chosen bits in a single write. Reading any alias returns the register it belongs to.

Pin sampling and interrupt qualification are left to a neighbouring block. This bank gives that block the live contents of every register. It also accepts a per-bit update of the data register from that block. Only bits whose direction is input take the update. When the neighbour and the bus touch the same data bit in one clock, the rule depends on the pin's direction. The neighbour wins on input pins and the bus wins on output pins.

Top module: `port_reg_bank`

## Requirements
- R1: While reset is held, and after it is released, every register reads as zero and every register output is zero.
- R2: A legal write to a base address stores the write data, and the next read returns it. The base addresses are data 0x00, maskA 0x10, maskB 0x20, direction 0x30, polarity 0x34, edge 0x38, both 0x3C and input-enable 0x40.
- R3: A write to a clear alias (base+0x4 of data, maskA or maskB) clears each bit of that register where the write data is 1. All other bits are left as they were.
- R4: A write to a set alias (base+0x8) ORs the write data into that register.
- R5: A write to a toggle alias (base+0xC) XORs the write data into that register.
- R6: Reading any of the four addresses of the data, maskA or maskB group returns that group's register.
- R7: Only a 16-bit access is legal. The size encoding is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit. Any other size raises the error flag, reads as zero and changes no register.
- R8: Some addresses raise the error flag, read as zero and change no register. These are any address above 0x40 and any address whose low two bits are not zero.
- R9: A pin update loads the update value into each data bit whose update enable is 1 and whose direction bit is 0 (input). On such a bit it wins over a bus write to the data group in the same clock.
- R10: On data bits whose direction bit is 1 (output), the pin update has no effect. A same-clock bus write to the data group decides those bits.
- R11: Every register is driven on its own output port, and a write shows there from the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access present this cycle |
| busWe | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 7 | Byte address within the bank |
| busSize | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data; zero when there is no access or on error |
| busErr | output | 1 | Error response for the current access |
| pinWe | input | 16 | Per-bit update enable from the pin block |
| pinVal | input | 16 | Update values from the pin block |
| dataQ | output | 16 | Data register contents |
| maskAQ | output | 16 | Interrupt mask A contents |
| maskBQ | output | 16 | Interrupt mask B contents |
| dirQ | output | 16 | Direction register (1 = output) |
| polarQ | output | 16 | Polarity register |
| edgeQ | output | 16 | Edge-select register |
| bothQ | output | 16 | Both-edges register |
| inenQ | output | 16 | Input-enable register |

## Verification
The alias operations are tried on the data, maskA and maskB groups with several patterns:

- Each pattern mixes bits that are already 1 with bits that are 0. This separates clear, set, toggle and plain write, because each gives a different result.
- Each alias is read back through a different address of its group, so a decode that maps aliases to the wrong register shows up.

The errors are tried one at a time:

- an address above the map;
- an address that is not 4-byte aligned;
- an 8-bit access;
- a 32-bit access.

After each error the register is read back, which shows that no state changed.

The pin-update tests run with two direction settings. The first has every pin an input. The second has the upper byte as outputs. The collision test writes bus data in the same clock as a pin update. The upper byte and the lower byte then expose opposite winners.

// File: rtl/prb_pkg.sv
package prb_pkg;

  // Aliased groups: data, maskA, maskB. Plain registers: dir, polar, edge, both, inen.
  localparam int NUM_ALIAS   = 3;
  localparam int NUM_PLAIN   = 5;
  localparam int OPS_PER_GRP = 4;

  // Position within a group; the address order depends on this encoding.
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_TOGGLE = 2'd3
  } aliasOp_e;

  typedef struct packed {
    logic [NUM_ALIAS-1:0] aliasWe;
    aliasOp_e             op;
    logic [NUM_PLAIN-1:0] plainWe;
    logic [4:0]           rdIdx;
    logic                 rdEn;
    logic                 err;
  } ctrlStrobe_t;

endpackage

// File: rtl/prb_ctrl.sv
module prb_ctrl
  import prb_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ctrlStrobe_t       strb
);

  localparam int          IDX_W      = ADDR_W - 2;
  localparam int          ALIAS_SPAN = NUM_ALIAS * OPS_PER_GRP;
  localparam int          LAST_IDX   = ALIAS_SPAN + NUM_PLAIN - 1;
  localparam logic [1:0]  SIZE_HALF  = 2'd1;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] grp;
  logic             badSize;
  logic             badAlign;
  logic             badRange;
  logic             wrOk;

  assign idx      = busAddr[ADDR_W-1:2];
  assign grp      = idx >> 2;
  assign badSize  = (busSize != SIZE_HALF);
  assign badAlign = |busAddr[1:0];
  assign badRange = (idx > IDX_W'(LAST_IDX));
  assign wrOk     = busSel && busWe && !strb.err;

  always_comb begin
    strb.err   = busSel && (badSize || badAlign || badRange);
    strb.rdEn  = busSel && !strb.err;
    strb.rdIdx = 5'(idx);
    strb.op    = aliasOp_e'(idx[1:0]);
    for (int g = 0; g < NUM_ALIAS; g++) begin
      strb.aliasWe[g] = wrOk && (idx < IDX_W'(ALIAS_SPAN)) && (grp == IDX_W'(g));
    end
    for (int k = 0; k < NUM_PLAIN; k++) begin
      strb.plainWe[k] = wrOk && (idx == IDX_W'(ALIAS_SPAN + k));
    end
  end

endmodule

// File: rtl/prb_dp.sv
module prb_dp
  import prb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrobe_t                         strb,
  input  logic [DATA_W-1:0]                   busWdata,
  input  logic [DATA_W-1:0]                   pinWe,
  input  logic [DATA_W-1:0]                   pinVal,
  output logic [NUM_ALIAS-1:0][DATA_W-1:0]    aliasQ,
  output logic [NUM_PLAIN-1:0][DATA_W-1:0]    plainQ,
  output logic [DATA_W-1:0]                   busRdata
);

  localparam int ALIAS_SPAN = NUM_ALIAS * OPS_PER_GRP;
  localparam int DIR_SLOT   = 0;

  // Input pins (direction 0) with an update request take the pin value.
  logic [DATA_W-1:0] pinTake;
  assign pinTake = pinWe & ~plainQ[DIR_SLOT];

  for (genvar g = 0; g < NUM_ALIAS; g++) begin : gAlias
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] busNext;
    logic [DATA_W-1:0] regNext;

    always_comb begin
      busNext = q;
      if (strb.aliasWe[g]) begin
        unique case (strb.op)
          OP_WRITE:  busNext = busWdata;
          OP_CLEAR:  busNext = q & ~busWdata;
          OP_SET:    busNext = q | busWdata;
          OP_TOGGLE: busNext = q ^ busWdata;
          default:   busNext = q;
        endcase
      end
    end

    if (g == 0) begin : gPinMerge
      assign regNext = (busNext & ~pinTake) | (pinVal & pinTake);
    end else begin : gBusOnly
      assign regNext = busNext;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else       q <= regNext;
    end

    assign aliasQ[g] = q;
  end

  for (genvar k = 0; k < NUM_PLAIN; k++) begin : gPlain
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                q <= '0;
      else if (strb.plainWe[k]) q <= busWdata;
    end
    assign plainQ[k] = q;
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      for (int g = 0; g < NUM_ALIAS; g++) begin
        if ((strb.rdIdx >> 2) == 5'(g) && strb.rdIdx < 5'(ALIAS_SPAN)) busRdata = aliasQ[g];
      end
      for (int k = 0; k < NUM_PLAIN; k++) begin
        if (strb.rdIdx == 5'(ALIAS_SPAN + k)) busRdata = plainQ[k];
      end
    end
  end

endmodule

// File: rtl/port_reg_bank.sv
module port_reg_bank
  import prb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic [DATA_W-1:0] pinWe,
  input  logic [DATA_W-1:0] pinVal,
  output logic [DATA_W-1:0] dataQ,
  output logic [DATA_W-1:0] maskAQ,
  output logic [DATA_W-1:0] maskBQ,
  output logic [DATA_W-1:0] dirQ,
  output logic [DATA_W-1:0] polarQ,
  output logic [DATA_W-1:0] edgeQ,
  output logic [DATA_W-1:0] bothQ,
  output logic [DATA_W-1:0] inenQ
);

  ctrlStrobe_t                        strb;
  logic [NUM_ALIAS-1:0][DATA_W-1:0]   aliasQ;
  logic [NUM_PLAIN-1:0][DATA_W-1:0]   plainQ;

  prb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busSize (busSize),
    .strb    (strb)
  );

  prb_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .pinWe    (pinWe),
    .pinVal   (pinVal),
    .aliasQ   (aliasQ),
    .plainQ   (plainQ),
    .busRdata (busRdata)
  );

  assign busErr = strb.err;
  assign dataQ  = aliasQ[0];
  assign maskAQ = aliasQ[1];
  assign maskBQ = aliasQ[2];
  assign dirQ   = plainQ[0];
  assign polarQ = plainQ[1];
  assign edgeQ  = plainQ[2];
  assign bothQ  = plainQ[3];
  assign inenQ  = plainQ[4];

endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic [DATA_W-1:0] pinWe,
  input logic [DATA_W-1:0] pinVal,
  input logic [DATA_W-1:0] dataQ,
  input logic [DATA_W-1:0] maskAQ,
  input logic [DATA_W-1:0] dirQ
);

  logic [DATA_W-1:0] inTake;
  logic              busGood;
  assign inTake  = pinWe & ~dirQ;
  assign busGood = busSel && !busErr;

  // R7: any size other than 16-bit is flagged
  a_r7_size_err: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busSize != 2'd1) |-> busErr);

  // R7: an errored write leaves the mask and direction registers untouched
  a_r7_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && busWe) |=> ($stable(maskAQ) && $stable(dirQ)));

  // R8: errored accesses read as zero
  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0));

  // R6: every maskA-group address returns maskA
  a_r6_maska_alias: assert property (@(posedge clk) disable iff (!rstN)
    (busGood && busAddr[ADDR_W-1:4] == 3'd1) |-> (busRdata == maskAQ));

  // R9: input pins with an update request follow the update value
  a_r9_input_pin: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dataQ & $past(inTake)) == ($past(pinVal) & $past(inTake))));

  // R10: without a bus write, output data bits never move
  a_r10_output_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busGood && busWe) |=> (((dataQ ^ $past(dataQ)) & $past(dirQ)) == '0));

  // R4: a set-alias write leaves the written ones set (bits the pin took aside)
  a_r4_set: assert property (@(posedge clk) disable iff (!rstN)
    (busGood && busWe && busAddr == 7'h08) |=>
      ((dataQ & $past(busWdata & ~inTake)) == $past(busWdata & ~inTake)));

endmodule

bind port_reg_bank prb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
  .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
  .pinWe(pinWe), .pinVal(pinVal), .dataQ(dataQ), .maskAQ(maskAQ), .dirQ(dirQ)
);

// File: tb/test_port_reg_bank.sv
`timescale 1ns/1ps
module test_port_reg_bank;

  typedef struct packed {
    logic        isWr;
    logic [6:0]  addr;
    logic [1:0]  size;
    logic [15:0] wdata;
    logic [15:0] expRd;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h00, 2'd1, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1 data zero
    '{1'b1, 7'h00, 2'd1, 16'hA5A5, 16'h0000, 1'b0, 4'd2},  // R2 data write
    '{1'b0, 7'h00, 2'd1, 16'h0000, 16'hA5A5, 1'b0, 4'd2},  // R2
    '{1'b1, 7'h04, 2'd1, 16'h00FF, 16'h0000, 1'b0, 4'd3},  // R3 clear
    '{1'b0, 7'h08, 2'd1, 16'h0000, 16'hA500, 1'b0, 4'd3},  // R3 via set addr
    '{1'b1, 7'h08, 2'd1, 16'h000F, 16'h0000, 1'b0, 4'd4},  // R4 set
    '{1'b0, 7'h0C, 2'd1, 16'h0000, 16'hA50F, 1'b0, 4'd4},  // R4
    '{1'b1, 7'h0C, 2'd1, 16'hFFFF, 16'h0000, 1'b0, 4'd5},  // R5 toggle
    '{1'b0, 7'h04, 2'd1, 16'h0000, 16'h5AF0, 1'b0, 4'd5},  // R5
    '{1'b1, 7'h10, 2'd1, 16'h1234, 16'h0000, 1'b0, 4'd2},  // R2 maskA
    '{1'b1, 7'h14, 2'd1, 16'h0204, 16'h0000, 1'b0, 4'd3},  // R3
    '{1'b0, 7'h1C, 2'd1, 16'h0000, 16'h1030, 1'b0, 4'd6},  // R6
    '{1'b1, 7'h18, 2'd1, 16'h8001, 16'h0000, 1'b0, 4'd4},  // R4
    '{1'b1, 7'h1C, 2'd1, 16'h0031, 16'h0000, 1'b0, 4'd5},  // R5
    '{1'b0, 7'h10, 2'd1, 16'h0000, 16'h9000, 1'b0, 4'd6},  // R6
    '{1'b1, 7'h20, 2'd1, 16'hFFFF, 16'h0000, 1'b0, 4'd2},  // R2 maskB
    '{1'b1, 7'h2C, 2'd1, 16'h0F0F, 16'h0000, 1'b0, 4'd5},  // R5
    '{1'b1, 7'h24, 2'd1, 16'hF000, 16'h0000, 1'b0, 4'd3},  // R3
    '{1'b0, 7'h28, 2'd1, 16'h0000, 16'h00F0, 1'b0, 4'd6},  // R6
    '{1'b1, 7'h34, 2'd1, 16'hBEEF, 16'h0000, 1'b0, 4'd2},  // R2 polarity
    '{1'b0, 7'h34, 2'd1, 16'h0000, 16'hBEEF, 1'b0, 4'd2},
    '{1'b1, 7'h38, 2'd1, 16'h0001, 16'h0000, 1'b0, 4'd2},  // R2 edge
    '{1'b0, 7'h38, 2'd1, 16'h0000, 16'h0001, 1'b0, 4'd2},
    '{1'b1, 7'h3C, 2'd1, 16'h0002, 16'h0000, 1'b0, 4'd2},  // R2 both
    '{1'b0, 7'h3C, 2'd1, 16'h0000, 16'h0002, 1'b0, 4'd2},
    '{1'b1, 7'h40, 2'd1, 16'h0003, 16'h0000, 1'b0, 4'd2},  // R2 input-enable
    '{1'b0, 7'h40, 2'd1, 16'h0000, 16'h0003, 1'b0, 4'd2},
    '{1'b1, 7'h44, 2'd1, 16'h1111, 16'h0000, 1'b1, 4'd8},  // R8 beyond map
    '{1'b0, 7'h44, 2'd1, 16'h0000, 16'h0000, 1'b1, 4'd8},
    '{1'b1, 7'h02, 2'd1, 16'hFFFF, 16'h0000, 1'b1, 4'd8},  // R8 misaligned
    '{1'b0, 7'h00, 2'd1, 16'h0000, 16'h5AF0, 1'b0, 4'd8},  // R8 data unchanged
    '{1'b1, 7'h10, 2'd0, 16'hFFFF, 16'h0000, 1'b1, 4'd7},  // R7 byte write
    '{1'b0, 7'h10, 2'd2, 16'h0000, 16'h0000, 1'b1, 4'd7},  // R7 word read
    '{1'b0, 7'h10, 2'd1, 16'h0000, 16'h9000, 1'b0, 4'd7},  // R7 maskA unchanged
    '{1'b1, 7'h7C, 2'd1, 16'h1111, 16'h0000, 1'b1, 4'd8},  // R8 top of space
    '{1'b0, 7'h7C, 2'd1, 16'h0000, 16'h0000, 1'b1, 4'd8},
    '{1'b0, 7'h02, 2'd1, 16'h0000, 16'h0000, 1'b1, 4'd8}   // R8 misaligned read
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [1:0]  busSize = 2'd1;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busErr;
  logic [15:0] pinWe = '0;
  logic [15:0] pinVal = '0;
  logic [15:0] dataQ, maskAQ, maskBQ, dirQ, polarQ, edgeQ, bothQ, inenQ;

  int applied = 0;
  int fails = 0;

  always #4 clk = ~clk;

  port_reg_bank i_port_reg_bank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .pinWe(pinWe), .pinVal(pinVal), .dataQ(dataQ), .maskAQ(maskAQ), .maskBQ(maskBQ),
    .dirQ(dirQ), .polarQ(polarQ), .edgeQ(edgeQ), .bothQ(bothQ), .inenQ(inenQ)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one bus access at the falling edge; check combinational reply; commit at rising edge.
  task automatic busOp(input logic wr, input logic [6:0] a, input logic [1:0] sz,
                       input logic [15:0] wd, output logic [15:0] rd, output logic er);
    @(negedge clk);
    busSel = 1'b1; busWe = wr; busAddr = a; busSize = sz; busWdata = wd;
    #1;
    rd = busRdata; er = busErr;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWe = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    logic        er;
    repeat (3) @(posedge clk);
    #1;
    check("R1 dataQ in reset", {1'b0, dataQ}, 17'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      busOp(VECS[i].isWr, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd, er);
      applied++;
      if ({er, (VECS[i].isWr ? 16'h0 : rd)} !== {VECS[i].expErr, VECS[i].expRd}) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual err=%b rd=%h expected err=%b rd=%h",
                 VECS[i].req, i, er, rd, VECS[i].expErr, VECS[i].expRd);
      end
    end

    // R11: register contents visible on their outputs
    #1;
    check("R11 maskAQ", {1'b0, maskAQ}, {1'b0, 16'h9000});
    check("R11 maskBQ", {1'b0, maskBQ}, {1'b0, 16'h00F0});
    check("R11 polarQ", {1'b0, polarQ}, {1'b0, 16'hBEEF});
    check("R11 edge/both/inen", {1'b0, edgeQ ^ bothQ ^ inenQ}, {1'b0, 16'h0000});

    // R9: all pins input, pin update loads every bit
    @(negedge clk);
    pinWe = 16'hFFFF; pinVal = 16'h1234;
    @(negedge clk);
    pinWe = '0;
    check("R9 all inputs", {1'b0, dataQ}, {1'b0, 16'h1234});

    // R10: upper byte output, pin update only reaches the lower byte
    busOp(1'b1, 7'h30, 2'd1, 16'hFF00, rd, er);
    check("R11 dirQ", {1'b0, dirQ}, {1'b0, 16'hFF00});
    @(negedge clk);
    pinWe = 16'hFFFF; pinVal = 16'h0000;
    @(negedge clk);
    pinWe = '0;
    check("R10 outputs ignore pin", {1'b0, dataQ}, {1'b0, 16'h1200});

    // R9 and R10: same-clock bus write and pin update
    @(negedge clk);
    pinWe = 16'hFFFF; pinVal = 16'h0055;
    busOp(1'b1, 7'h00, 2'd1, 16'hABCD, rd, er);
    pinWe = '0;
    check("R9 R10 collision on write", {1'b0, dataQ}, {1'b0, 16'hAB55});

    // R4 with R9: set alias collides with pin clearing bits 7:4
    @(negedge clk);
    pinWe = 16'h00F0; pinVal = 16'h0000;
    busOp(1'b1, 7'h08, 2'd1, 16'h00FF, rd, er);
    pinWe = '0;
    check("R4 R9 set alias collision", {1'b0, dataQ}, {1'b0, 16'hAB0F});

    // R1: reset clears everything
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 data/mask after reset", {1'b0, dataQ | maskAQ | maskBQ}, 17'h0);
    check("R1 plain after reset", {1'b0, dirQ | polarQ | edgeQ | bothQ | inenQ}, 17'h0);
    @(negedge clk);
    rstN = 1'b1;
    busOp(1'b0, 7'h34, 2'd1, 16'h0, rd, er);
    check("R1 read after reset", {er, rd}, 17'h0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule